// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Lock Monitor

This block is the digital half of an integer-N frequency synthesizer. It runs on one core clock and receives the reference clock and the VCO clock as single-cycle edge strobes. A programmable reference counter brings the reference down to the comparison rate. A fixed feedback counter does the same for the VCO, whose nominal rate is twice the RF local oscillator. A tri-state phase-frequency detector turns the two divided edge streams into up and down requests for the external charge pump.

A second fixed counter on the VCO strobes makes a synthesized sample clock, and a select bit can replace it with the raw reference. A lock monitor sorts every phase comparison as tight, VCO-fast or VCO-slow. It keeps two sticky flags that report a VCO parked at the top or at the bottom of its range. A run control clears the whole divider chain. A standby control freezes the VCO side but leaves the reference path running.

Top module: `pll_div_core`

## Requirements
- R1: While rst_n is low and on the first sample after it, every output is 0.
- R2: With the 8-bit ratio field at N, tap_ref is high for one cycle right after every N-th ref_tick counted from release of the dividers. N = 0 behaves as N = 1, and the default parameter ratio is 96.
- R3: tap_fb is high for one cycle after every FB_DIV-th vco_tick (default 16128). The ratio is not programmable.
- R4: With ref_sel = 0, smp_tick is one pulse per SMP_DIV vco_ticks (default 192), delayed one cycle after the sample counter wraps.
- R5: With ref_sel = 1, smp_tick equals ref_tick delayed by one cycle, whatever the state of div_run and standby.
- R6: With standby = 1 and ref_sel = 1, the feedback counter, the sample counter and the phase detector are held, so tap_fb, pfd_up and pfd_dn stay 0, while the reference counter keeps dividing. With ref_sel = 0, standby has no effect.
- R7: While div_run = 0, all counters sit at zero, the phase detector is idle and both lock flags are 0. After release, the first tap_ref follows the N-th ref_tick.
- R8: Phase detector states PFD_IDLE, PFD_UP and PFD_DN. From idle, a tap_ref pulse enters PFD_UP (pfd_up high the next cycle) and a tap_fb pulse enters PFD_DN. The opposite pulse returns the detector to idle. Both taps in the same idle cycle keep it idle. pfd_up and pfd_dn are never high together.
- R9: lock_lost_hi becomes 1 after SLIP_CNT (default 4) consecutive VCO-fast comparisons. A comparison is VCO-fast when a tap_fb pulse arrives while in PFD_DN, or when a PFD_DN pulse longer than LOCK_WIN cycles ends.
- R10: lock_lost_lo becomes 1 after SLIP_CNT consecutive VCO-slow comparisons, defined in the same way with PFD_UP and tap_ref.
- R11: Monitor states LK_LOCKED, LK_HIGH and LK_LOW. A set flag stays set until SLIP_CNT consecutive tight comparisons return the monitor to LK_LOCKED. A tight comparison is both taps in one idle cycle, or a pulse of at most LOCK_WIN cycles. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| vco_tick | input | 1 | One-cycle strobe per VCO clock edge |
| ref_div | input | 8 | Reference division ratio |
| ref_sel | input | 1 | 1: sample clock from reference, 0: synthesized |
| standby | input | 1 | Freeze VCO side (only when ref_sel = 1) |
| div_run | input | 1 | 0 holds dividers, detector and monitor cleared |
| smp_tick | output | 1 | Selected sample clock strobe |
| pfd_up | output | 1 | Charge-pump up request |
| pfd_dn | output | 1 | Charge-pump down request |
| tap_ref | output | 1 | Divided reference pulse (test tap) |
| tap_fb | output | 1 | Divided VCO pulse (test tap) |
| lock_lost_hi | output | 1 | VCO stuck high flag |
| lock_lost_lo | output | 1 | VCO stuck low flag |

## Verification
On every cycle the assertions check several properties. The two detector requests and the two lock flags are never high together. A request only rises after the matching divided pulse, and a flag only rises after a cycle of the matching request. The reference pass-through is exact, and the run and standby controls hold the VCO side and the detector silent. The exact division counts, the R = 0 alias and the sticky clearing of a flag only show up in the bench's scenarios. The same goes for the boundary where the fourth, not the third, consecutive comparison changes a flag.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_st_e;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HIGH   = 2'd1,
        LK_LOW    = 2'd2
    } lk_st_e;

    typedef struct packed {
        logic tight;
        logic vco_fast;
        logic vco_slow;
    } cmp_ev_t;

endpackage

// File: rtl/pll_tick_div.sv
// Strobe divider: emits a one-cycle pulse after every ratio-th tick.
module pll_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);

    logic [W-1:0] cnt;
    logic         wrap;

    // cnt never exceeds ratio-1, so cnt+1 cannot overflow; ratio 0 wraps every tick
    assign wrap = (cnt + W'(1)) >= ratio;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (en && tick) begin
            cnt   <= wrap ? '0 : cnt + W'(1);
            pulse <= wrap;
        end else begin
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/pll_pfd_fsm.sv
// Tri-state phase-frequency detector with pulse-width classification.
module pll_pfd_fsm
    import pll_div_pkg::*;
#(
    parameter int LOCK_WIN = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    r_pls,
    input  logic    f_pls,
    output logic    up,
    output logic    dn,
    output cmp_ev_t ev
);

    localparam int WW = $clog2(LOCK_WIN + 2);
    localparam logic [WW-1:0] WIN_V = WW'(LOCK_WIN);
    localparam logic [WW-1:0] SAT_V = WW'(LOCK_WIN + 1);

    pfd_st_e       st, st_n;
    logic [WW-1:0] wcnt, wcnt_n;
    logic          short_pls;

    assign short_pls = (wcnt <= WIN_V);

    always_comb begin
        st_n   = st;
        wcnt_n = wcnt;
        ev     = '0;
        unique case (st)
            PFD_IDLE: begin
                wcnt_n = '0;
                if (r_pls && f_pls) begin
                    ev.tight = 1'b1;
                end else if (r_pls) begin
                    st_n   = PFD_UP;
                    wcnt_n = WW'(1);
                end else if (f_pls) begin
                    st_n   = PFD_DN;
                    wcnt_n = WW'(1);
                end
            end
            PFD_UP: begin
                wcnt_n = (wcnt == SAT_V) ? wcnt : wcnt + WW'(1);
                if (f_pls) begin
                    st_n        = PFD_IDLE;
                    wcnt_n      = '0;
                    ev.tight    = short_pls;
                    ev.vco_slow = !short_pls;
                end else if (r_pls) begin
                    ev.vco_slow = 1'b1;
                end
            end
            PFD_DN: begin
                wcnt_n = (wcnt == SAT_V) ? wcnt : wcnt + WW'(1);
                if (r_pls) begin
                    st_n        = PFD_IDLE;
                    wcnt_n      = '0;
                    ev.tight    = short_pls;
                    ev.vco_fast = !short_pls;
                end else if (f_pls) begin
                    ev.vco_fast = 1'b1;
                end
            end
            default: begin
                st_n   = PFD_IDLE;
                wcnt_n = '0;
            end
        endcase
        if (clr) begin
            ev = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= PFD_IDLE;
            wcnt <= '0;
        end else if (clr) begin
            st   <= PFD_IDLE;
            wcnt <= '0;
        end else begin
            st   <= st_n;
            wcnt <= wcnt_n;
        end
    end

    always_comb begin
        up = (st == PFD_UP);
        dn = (st == PFD_DN);
    end

endmodule

// File: rtl/pll_lock_mon.sv
// Sticky out-of-lock monitor driven by classified comparisons.
module pll_lock_mon
    import pll_div_pkg::*;
#(
    parameter int SLIP_CNT = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  cmp_ev_t ev,
    output logic    flag_hi,
    output logic    flag_lo
);

    localparam int CW = $clog2(SLIP_CNT + 1);
    localparam logic [CW-1:0] LIM = CW'(SLIP_CNT);

    lk_st_e        st, st_n;
    logic [CW-1:0] n_fast, n_slow, n_tight;
    logic [CW-1:0] n_fast_n, n_slow_n, n_tight_n;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
        return (v == LIM) ? v : v + CW'(1);
    endfunction

    always_comb begin
        st_n      = st;
        n_fast_n  = n_fast;
        n_slow_n  = n_slow;
        n_tight_n = n_tight;
        if (ev.vco_fast) begin
            n_fast_n  = bump(n_fast);
            n_slow_n  = '0;
            n_tight_n = '0;
        end else if (ev.vco_slow) begin
            n_slow_n  = bump(n_slow);
            n_fast_n  = '0;
            n_tight_n = '0;
        end else if (ev.tight) begin
            n_tight_n = bump(n_tight);
            n_fast_n  = '0;
            n_slow_n  = '0;
        end
        unique case (st)
            LK_LOCKED: begin
                if (n_fast_n >= LIM)      st_n = LK_HIGH;
                else if (n_slow_n >= LIM) st_n = LK_LOW;
            end
            LK_HIGH: begin
                if (n_tight_n >= LIM)     st_n = LK_LOCKED;
                else if (n_slow_n >= LIM) st_n = LK_LOW;
            end
            LK_LOW: begin
                if (n_tight_n >= LIM)     st_n = LK_LOCKED;
                else if (n_fast_n >= LIM) st_n = LK_HIGH;
            end
            default: st_n = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= LK_LOCKED;
            n_fast  <= '0;
            n_slow  <= '0;
            n_tight <= '0;
        end else if (clr) begin
            st      <= LK_LOCKED;
            n_fast  <= '0;
            n_slow  <= '0;
            n_tight <= '0;
        end else begin
            st      <= st_n;
            n_fast  <= n_fast_n;
            n_slow  <= n_slow_n;
            n_tight <= n_tight_n;
        end
    end

    always_comb begin
        flag_hi = (st == LK_HIGH);
        flag_lo = (st == LK_LOW);
    end

endmodule

// File: rtl/pll_div_core.sv
module pll_div_core
    import pll_div_pkg::*;
#(
    parameter int RW       = 8,
    parameter int FB_DIV   = 16128,
    parameter int SMP_DIV  = 192,
    parameter int LOCK_WIN = 4,
    parameter int SLIP_CNT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          vco_tick,
    input  logic [RW-1:0] ref_div,
    input  logic          ref_sel,
    input  logic          standby,
    input  logic          div_run,
    output logic          smp_tick,
    output logic          pfd_up,
    output logic          pfd_dn,
    output logic          tap_ref,
    output logic          tap_fb,
    output logic          lock_lost_hi,
    output logic          lock_lost_lo
);

    localparam int FBW = $clog2(FB_DIV + 1);
    localparam int SMW = $clog2(SMP_DIV + 1);
    localparam logic [FBW-1:0] FB_RATIO  = FBW'(FB_DIV);
    localparam logic [SMW-1:0] SMP_RATIO = SMW'(SMP_DIV);

    logic          hold_all;
    logic          hold_vco;
    logic [RW-1:0] ref_eff;
    logic          smp_syn;
    cmp_ev_t       cmp_ev;

    assign hold_all = !div_run;
    assign hold_vco = hold_all || (standby && ref_sel);
    assign ref_eff  = (ref_div == '0) ? RW'(1) : ref_div;

    pll_tick_div #(.W(RW)) u_refdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_all),
        .en    (1'b1),
        .tick  (ref_tick),
        .ratio (ref_eff),
        .pulse (tap_ref)
    );

    pll_tick_div #(.W(FBW)) u_fbdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_vco),
        .en    (1'b1),
        .tick  (vco_tick),
        .ratio (FB_RATIO),
        .pulse (tap_fb)
    );

    pll_tick_div #(.W(SMW)) u_smpdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_vco),
        .en    (1'b1),
        .tick  (vco_tick),
        .ratio (SMP_RATIO),
        .pulse (smp_syn)
    );

    pll_pfd_fsm #(.LOCK_WIN(LOCK_WIN)) u_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (hold_vco),
        .r_pls (tap_ref),
        .f_pls (tap_fb),
        .up    (pfd_up),
        .dn    (pfd_dn),
        .ev    (cmp_ev)
    );

    pll_lock_mon #(.SLIP_CNT(SLIP_CNT)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_all),
        .ev      (cmp_ev),
        .flag_hi (lock_lost_hi),
        .flag_lo (lock_lost_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_tick <= 1'b0;
        end else begin
            smp_tick <= ref_sel ? ref_tick : smp_syn;
        end
    end

endmodule

// File: rtl/pll_div_core_chk.sv
module pll_div_core_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic ref_sel,
    input logic standby,
    input logic div_run,
    input logic smp_tick,
    input logic pfd_up,
    input logic pfd_dn,
    input logic tap_ref,
    input logic tap_fb,
    input logic lock_lost_hi,
    input logic lock_lost_lo
);

    assert_up_dn_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfd_up && pfd_dn));

    assert_up_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_up) |-> $past(tap_ref));

    assert_dn_after_fb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pfd_dn) |-> $past(tap_fb));

    assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_lost_hi && lock_lost_lo));

    assert_hi_needs_dn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost_hi) |-> $past(pfd_dn));

    assert_lo_needs_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost_lo) |-> $past(pfd_up));

    assert_ref_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ref_sel) |-> (smp_tick == $past(ref_tick)));

    assert_standby_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && ref_sel) |=> (!tap_fb && !pfd_up && !pfd_dn));

    assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !div_run |=> (!tap_ref && !tap_fb && !pfd_up && !pfd_dn
                      && !lock_lost_hi && !lock_lost_lo));

endmodule

bind pll_div_core pll_div_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .ref_sel      (ref_sel),
    .standby      (standby),
    .div_run      (div_run),
    .smp_tick     (smp_tick),
    .pfd_up       (pfd_up),
    .pfd_dn       (pfd_dn),
    .tap_ref      (tap_ref),
    .tap_fb       (tap_fb),
    .lock_lost_hi (lock_lost_hi),
    .lock_lost_lo (lock_lost_lo)
);

// File: tb/pll_div_core_tb.sv
module pll_div_core_tb;

    localparam int FBD = 24;
    localparam int SMD = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       vco_tick = 1'b0;
    logic [7:0] ref_div = 8'd96;
    logic       ref_sel = 1'b1;
    logic       standby = 1'b0;
    logic       div_run = 1'b0;
    logic       smp_tick, pfd_up, pfd_dn, tap_ref, tap_fb, lock_lost_hi, lock_lost_lo;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pll_div_core #(.FB_DIV(FBD), .SMP_DIV(SMD), .LOCK_WIN(4), .SLIP_CNT(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
        .ref_div(ref_div), .ref_sel(ref_sel), .standby(standby), .div_run(div_run),
        .smp_tick(smp_tick), .pfd_up(pfd_up), .pfd_dn(pfd_dn), .tap_ref(tap_ref),
        .tap_fb(tap_fb), .lock_lost_hi(lock_lost_hi), .lock_lost_lo(lock_lost_lo)
    );

    function automatic int eff_ratio(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v);
        @(negedge clk);
        ref_tick = r;
        vco_tick = v;
        @(posedge clk);
        #1;
    endtask

    task automatic restart();
        div_run = 1'b0;
        step(0, 0);
        div_run = 1'b1;
    endtask

    task automatic ref_ratio_trial(input int n);
        int cnt = 0;
        int seen = 0;
        ref_div = 8'(n);
        restart();
        for (int i = 0; i < 4000 && seen < 3; i++) begin
            logic r;
            r = 1'($urandom_range(0, 1));
            step(r, 0);
            if (r) cnt++;
            if (tap_ref) begin
                chk("R2 ref ratio", cnt, eff_ratio(n));
                cnt = 0;
                seen++;
            end
        end
        chk("R2 pulses seen", seen, 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int cnt, pulses, pu;
        void'($urandom(32'd5150));
        repeat (3) step(0, 0);
        chk("R1 outputs in reset", {smp_tick, pfd_up, pfd_dn, tap_ref, tap_fb,
                                    lock_lost_hi, lock_lost_lo}, 0);
        rst_n = 1'b1;
        step(0, 0);
        chk("R1 outputs after reset", {smp_tick, pfd_up, pfd_dn, tap_ref, tap_fb,
                                       lock_lost_hi, lock_lost_lo}, 0);

        // R2: directed corners then random ratios
        ref_ratio_trial(0);
        ref_ratio_trial(1);
        ref_ratio_trial(96);
        ref_ratio_trial(255);
        for (int k = 0; k < 5; k++) ref_ratio_trial($urandom_range(2, 40));

        // R3: feedback ratio
        restart();
        cnt = 0; pulses = 0;
        for (int i = 0; i < 2000 && pulses < 3; i++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            step(0, v);
            if (v) cnt++;
            if (tap_fb) begin
                chk("R3 fb ratio", cnt, FBD);
                cnt = 0;
                pulses++;
            end
        end
        chk("R3 pulses seen", pulses, 3);

        // R4: synthesized sample clock
        ref_sel = 1'b0;
        restart();
        cnt = 0; pulses = 0;
        for (int i = 0; i < 2000 && pulses < 4; i++) begin
            logic v;
            v = 1'($urandom_range(0, 1));
            step(0, v);
            if (smp_tick) begin
                if (pulses > 0) chk("R4 sample ratio", cnt, SMD);
                cnt = int'(v);
                pulses++;
            end else begin
                cnt += int'(v);
            end
        end
        chk("R4 pulses seen", pulses, 4);

        // R5: reference pass-through
        ref_sel = 1'b1;
        pulses = 0;
        for (int i = 0; i < 40; i++) begin
            logic r;
            r = 1'($urandom_range(0, 1));
            step(r, 1'($urandom_range(0, 1)));
            if (smp_tick != r) pulses++;
        end
        chk("R5 pass-through mismatches", pulses, 0);

        // R6: standby with reference selected
        standby = 1'b1;
        ref_div = 8'd2;
        restart();
        cnt = 0; pulses = 0; pu = 0;
        for (int i = 0; i < 100; i++) begin
            step(1, 1);
            cnt += int'(tap_ref);
            pulses += int'(tap_fb);
            pu += int'(pfd_up) + int'(pfd_dn);
        end
        chk("R6 ref divides in standby", cnt, 50);
        chk("R6 fb held in standby", pulses, 0);
        chk("R6 pfd held in standby", pu, 0);
        // R6: standby ignored with synthesized clock
        ref_sel = 1'b0;
        restart();
        cnt = 0; pulses = 0;
        for (int i = 0; i < 62; i++) begin
            step(0, i < 60);
            cnt += int'(smp_tick);
            pulses += int'(tap_fb);
        end
        chk("R6 standby ignored fb", pulses, 2);
        chk("R6 standby ignored smp", cnt, 10);
        standby = 1'b0;
        ref_sel = 1'b1;

        // R8: phase detector sequences
        ref_div = 8'd1;
        restart();
        step(1, 0);
        step(0, 0);
        chk("R8 up after ref", {pfd_up, pfd_dn}, 2);
        for (int i = 0; i < FBD; i++) step(0, 1);
        chk("R8 fb tap", tap_fb, 1);
        step(0, 0);
        chk("R8 up cleared by fb", {pfd_up, pfd_dn}, 0);
        for (int i = 0; i < FBD; i++) step(0, 1);
        step(0, 0);
        chk("R8 dn after fb", {pfd_up, pfd_dn}, 1);
        step(1, 0);
        step(0, 0);
        chk("R8 dn cleared by ref", {pfd_up, pfd_dn}, 0);
        for (int i = 0; i < FBD - 1; i++) step(0, 1);
        step(1, 1);
        chk("R8 both taps together", {tap_ref, tap_fb}, 3);
        step(0, 0);
        chk("R8 simultaneous stays idle", {pfd_up, pfd_dn}, 0);

        // R10: VCO stalled
        restart();
        for (int p = 0; p < 4; p++) begin
            step(1, 0);
            repeat (9) step(0, 0);
        end
        chk("R10 lo not after three slow", lock_lost_lo, 0);
        step(1, 0);
        repeat (9) step(0, 0);
        chk("R10 lo after four slow", lock_lost_lo, 1);
        chk("R10 hi stays clear", lock_lost_hi, 0);
        repeat (50) step(0, 0);
        chk("R11 lo sticky", lock_lost_lo, 1);

        // R11: aligned pairs; first closes the long up pulse, rest are tight
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < FBD - 1; i++) step(0, 1);
            step(1, 1);
            repeat (10) step(0, 0);
        end
        chk("R11 lo after three tight", lock_lost_lo, 1);
        for (int i = 0; i < FBD - 1; i++) step(0, 1);
        step(1, 1);
        repeat (10) step(0, 0);
        chk("R11 lo cleared after four tight", lock_lost_lo, 0);
        chk("R11 hi clear", lock_lost_hi, 0);

        // R9: VCO running fast
        for (int p = 0; p < 10; p++) begin
            for (int i = 0; i < 59; i++) step(0, 1);
            step(1, 1);
        end
        repeat (3) step(0, 0);
        chk("R9 hi after fast run", lock_lost_hi, 1);
        chk("R9 lo clear", lock_lost_lo, 0);

        // R7: run low clears flags and counters
        ref_div = 8'd5;
        div_run = 1'b0;
        step(1, 1);
        step(1, 1);
        chk("R7 cleared while held", {tap_ref, tap_fb, pfd_up, pfd_dn,
                                      lock_lost_hi, lock_lost_lo}, 0);
        div_run = 1'b1;
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            step(1, 0);
            cnt++;
            if (tap_ref) break;
        end
        chk("R7 first tap after release", cnt, 5);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule